// File: doc/BRIEF.md
# Flash Status Toggle-Bit Generator

This block produces the status byte that a NOR-style flash returns while an embedded program or erase is running. The host polls by reading twice and comparing. A bit that differs between the two reads means the operation is still running. A bit that matches means it has finished. Two independent toggle bits are kept. Bit 6 flips on every status read while an operation is active. Bit 2 flips only on reads whose address falls in a sector selected for erase, including while that erase is suspended.

The block follows the erase life cycle:
- start erase;
- suspend it;
- optionally run a program inside the suspension;
- resume the erase;
- finish.

The set of selected sectors is captured when the erase starts. A read is one cycle with either the output-enable strobe or the chip-enable strobe high. The algorithm timing and the array contents belong to the surrounding model.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset the status byte is 8'h00 and the block is idle with no sector selected.
- R2: While a program, an erase, or a program inside an erase suspension is active, each read access inverts status bit 6 on the clock edge that samples it.
- R3: A read access is any cycle with `oe_rd` or `ce_rd` high; both high in one cycle count as a single access.
- R4: Once `op_done` ends a program or an erase and the block is idle, reads leave status bits 6 and 2 unchanged.
- R5: Status bit 2 inverts on a read exactly when the sector index is in the captured erase mask. The sector index is the top log2(SECTORS) bits of `rd_addr`. Bit 2 holds on every other read. The mask is captured from `sect_sel` at erase start, is kept through suspend and resume, and is cleared when the erase completes.
- R6: During an erase suspension with no program running, bit 6 holds on reads at every address.
- R7: An accepted start clears bits 6 and 2 to 0 on that edge, even if a read occurs in the same cycle. Accepted starts are any start while idle, and a program start (`op_erase`=0) while erase-suspended.
- R8: `susp_req` moves a running erase into suspension. `resume_req` returns a suspension with no program running to the erase. `op_done` during a suspended program returns to the suspension.
- R9: Status bits 7, 5, 4, 3, 1 and 0 always read 0.
- R10: Commands not valid in the current phase are ignored:
  - a start during a running operation;
  - an erase start while suspended;
  - a suspend during a program;
  - a resume while erasing;
  - `op_done` while idle or suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_rd | input | 1 | Read access framed by output enable |
| ce_rd | input | 1 | Read access framed by chip enable |
| rd_addr | input | ADDR_W | Address of the read access |
| op_start | input | 1 | Start an embedded operation |
| op_erase | input | 1 | With `op_start`: 1 = erase, 0 = program |
| sect_sel | input | SECTORS | Sectors selected for an erase start |
| op_done | input | 1 | The running embedded operation has finished |
| susp_req | input | 1 | Suspend the running erase |
| resume_req | input | 1 | Resume the suspended erase |
| status | output | 8 | Status byte: bit 6 and bit 2 toggle bits |

## Verification
Every result comes from a single register stage. A read or command presented in one cycle is reflected on `status` right after the next rising edge, and never before. The bench drives each stimulus on a falling edge and removes it on the following falling edge. It compares `status` at that same moment against a phase-and-mask model written from the requirements. It also compares after stimulus-free cycles, which shows that nothing moves without a read. The sweep covers every erase mask of the four-sector configuration at every sector, across all five phases.

// File: rtl/flash_toggle_status.sv
module flash_toggle_status #(
  parameter int ADDR_W  = 8,
  parameter int SECTORS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oe_rd,
  input  logic               ce_rd,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               op_start,
  input  logic               op_erase,
  input  logic [SECTORS-1:0] sect_sel,
  input  logic               op_done,
  input  logic               susp_req,
  input  logic               resume_req,
  output logic [7:0]         status
);
  localparam int SEC_W = $clog2(SECTORS);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PROG  = 3'd1,
    PH_ERASE = 3'd2,
    PH_SUSP  = 3'd3,
    PH_SPROG = 3'd4
  } phase_t;

  phase_t             mode;
  logic [SECTORS-1:0] erase_mask;
  logic               tog6, tog2;

  wire             rd_any  = oe_rd | ce_rd;
  wire [SEC_W-1:0] sector  = rd_addr[ADDR_W-1 -: SEC_W];
  wire             hit     = erase_mask[sector];
  wire             active  = (mode == PH_PROG) || (mode == PH_ERASE) || (mode == PH_SPROG);
  wire             accept  = op_start && ((mode == PH_IDLE) || (mode == PH_SUSP && !op_erase));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= PH_IDLE;
      erase_mask <= '0;
      tog6       <= 1'b0;
      tog2       <= 1'b0;
    end else if (accept) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
      if (mode == PH_SUSP) begin
        mode <= PH_SPROG;
      end else if (op_erase) begin
        mode       <= PH_ERASE;
        erase_mask <= sect_sel;
      end else begin
        mode <= PH_PROG;
      end
    end else begin
      if (rd_any && active) tog6 <= ~tog6;
      if (rd_any && hit)    tog2 <= ~tog2;
      case (mode)
        PH_PROG:  if (op_done) mode <= PH_IDLE;
        PH_ERASE: begin
          if (op_done) begin
            mode       <= PH_IDLE;
            erase_mask <= '0;
          end else if (susp_req) begin
            mode <= PH_SUSP;
          end
        end
        PH_SUSP:  if (resume_req) mode <= PH_ERASE;
        PH_SPROG: if (op_done) mode <= PH_SUSP;
        default:  mode <= PH_IDLE;
      endcase
    end
  end

  assign status = {1'b0, tog6, 3'b000, tog2, 2'b00};
endmodule

module flash_toggle_status_chk #(
  parameter int ADDR_W  = 8,
  parameter int SECTORS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               oe_rd,
  input logic               ce_rd,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               op_start,
  input logic               op_erase,
  input logic [2:0]         mode,
  input logic [SECTORS-1:0] erase_mask,
  input logic [7:0]         status
);
  localparam int SEC_W = $clog2(SECTORS);
  wire rd   = oe_rd | ce_rd;
  wire hit  = erase_mask[rd_addr[ADDR_W-1 -: SEC_W]];
  wire acc  = op_start && (mode == 3'd0 || (mode == 3'd3 && !op_erase));
  wire runs = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd4);

  // R9
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'hBB) == 8'h00);

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> status == 8'h00);

  // R2
  bit6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && runs && !acc |=> status[6] != $past(status[6]));

  // R4 R6
  bit6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd3) && !acc |=> $stable(status[6]));

  // R5
  bit2_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && hit && !acc |=> status[2] != $past(status[2]));

  // R5
  bit2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && hit) && !acc |=> $stable(status[2]));
endmodule

bind flash_toggle_status flash_toggle_status_chk #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) chk (
  .clk(clk), .rst_n(rst_n), .oe_rd(oe_rd), .ce_rd(ce_rd), .rd_addr(rd_addr),
  .op_start(op_start), .op_erase(op_erase), .mode(mode), .erase_mask(erase_mask),
  .status(status)
);

// File: tb/flash_toggle_status_test.sv
module flash_toggle_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oe_rd = 0, ce_rd = 0, op_start = 0, op_erase = 0, op_done = 0, susp_req = 0, resume_req = 0;
  logic [7:0] rd_addr = '0;
  logic [3:0] sect_sel = '0;
  logic [7:0] status;

  int checks = 0, fails = 0;
  int m = 0;             // 0 idle 1 prog 2 erase 3 susp 4 susp-prog
  logic [3:0] mask = '0;
  logic e6 = 0, e2 = 0;

  always #10 clk = ~clk;

  flash_toggle_status #(.ADDR_W(8), .SECTORS(4)) uut (
    .clk(clk), .rst_n(rst_n), .oe_rd(oe_rd), .ce_rd(ce_rd), .rd_addr(rd_addr),
    .op_start(op_start), .op_erase(op_erase), .sect_sel(sect_sel), .op_done(op_done),
    .susp_req(susp_req), .resume_req(resume_req), .status(status)
  );

  task automatic check(input string req);
    logic [7:0] exp;
    exp = {1'b0, e6, 3'b000, e2, 2'b00};
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic cyc(input logic oe, input logic ce, input logic [7:0] a,
                     input logic st, input logic er, input logic [3:0] sel,
                     input logic dn, input logic sp, input logic rs);
    logic rd;
    @(negedge clk);
    oe_rd = oe; ce_rd = ce; rd_addr = a; op_start = st; op_erase = er;
    sect_sel = sel; op_done = dn; susp_req = sp; resume_req = rs;
    @(negedge clk);
    oe_rd = 0; ce_rd = 0; op_start = 0; op_erase = 0; op_done = 0; susp_req = 0; resume_req = 0;
    rd = oe | ce;
    if (st && (m == 0 || (m == 3 && !er))) begin
      e6 = 0; e2 = 0;
      if (m == 3) m = 4;
      else if (er) begin m = 2; mask = sel; end
      else m = 1;
    end else begin
      if (rd && (m == 1 || m == 2 || m == 4)) e6 = ~e6;
      if (rd && mask[a[7:6]]) e2 = ~e2;
      case (m)
        1: if (dn) m = 0;
        2: if (dn) begin m = 0; mask = 0; end else if (sp) m = 3;
        3: if (rs) m = 2;
        4: if (dn) m = 3;
        default: ;
      endcase
    end
  endtask

  task automatic rd_all(input string req);
    for (int s = 0; s < 4; s++) begin
      cyc(s[0], ~s[0], {s[1:0], 6'h15}, 0, 0, 0, 0, 0, 0);
      check(req);
    end
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    cyc(1, 0, 8'hC0, 0, 0, 0, 0, 0, 0); check("R1 idle read holds");

    cyc(0, 0, 0, 1, 0, 4'hF, 0, 0, 0); check("R7 program start");
    rd_all("R2 program reads");
    cyc(1, 1, 8'h40, 0, 0, 0, 0, 0, 0); check("R3 both strobes one access");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0); check("R10 suspend during program");
    cyc(1, 0, 8'h00, 1, 1, 4'hF, 0, 0, 0); check("R10 start while programming");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0); check("R4 program done");
    rd_all("R4 idle reads hold");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0); check("R10 done while idle");

    for (int mk = 0; mk < 16; mk++) begin
      cyc(1, 0, 8'h00, 1, 1, mk[3:0], 0, 0, 0); check("R7 erase start with read");
      rd_all("R5 erase reads");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); check("R10 resume while erasing");
      cyc(0, 1, 8'hFF, 0, 0, 0, 0, 0, 0); check("R2 erase read");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 0); check("R8 suspend");
      rd_all("R6 suspend reads");
      cyc(0, 0, 0, 1, 1, 4'h0, 0, 0, 0); check("R10 erase start while suspended");
      cyc(0, 0, 0, 0, 0, 0, 1, 0, 0); check("R10 done while suspended");
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0); check("R7 program in suspend");
      rd_all("R5 suspend-program reads");
      cyc(0, 0, 0, 0, 0, 0, 1, 0, 0); check("R8 suspend-program done");
      rd_all("R6 back in suspend");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); check("R8 resume");
      rd_all("R8 resumed erase reads");
      cyc(1, 0, 8'h80, 0, 0, 0, 1, 0, 0); check("R4 erase done with read");
      rd_all("R4 mask cleared after erase");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule